// File: doc/BRIEF.md
# Tournament Knockout Cell Concentrator

This block sits at one output of a self-routing switch. In every clock cycle (one slot) it receives up to N cells that have already been found to share that output. Each cell is a valid flag plus a payload word. At most L of them go out on L output lanes. The rest are discarded, and the block reports how many it discarded in that slot.

Selection is a tournament. The first division is a single-elimination tree of two-input contention elements over all N inputs, and its champion takes output lane 1. Every cell that loses a match in division k is handed to division k+1. Each later division is a tree of the same shape, and its champion takes lane k+1. A cell that loses in the last division is discarded. Each contention element holds a toggle flip-flop that decides contested matches, so no input is favoured in the long run. The selection network is combinational within a slot, and the lanes and the drop count are registered.

Top module: `knockout_concentrator`

## Requirements
- R1: While reset is active and right after it is released, every output lane is invalid and the drop count is zero.
- R2: If K valid cells arrive in a slot and K is no more than L, those K payloads appear on lanes 1 through K (out_vld bits 0 to K-1), and lanes K+1 through L are invalid.
- R3: If K exceeds L, all L lanes are valid, so exactly L cells are forwarded.
- R4: drop_cnt equals K-L when K exceeds L, and zero otherwise.
- R5: Forwarded cells plus dropped cells equal K. Every forwarded payload is the payload of a valid input in that slot, and no input's payload appears on two lanes.
- R6: A lone valid cell always wins its match, and an invalid input never wins. With exactly one valid input, its payload is on lane 1 (out_dat bits W-1:0). A slot with no valid input yields no valid lane.
- R7: When two valid cells meet, the element's toggle decides the match and then flips. After reset, the first contested match is won by the lower-index side. When only inputs 0 and 1 are valid in successive slots, lane 1 therefore carries input 0, then input 1, and so on alternately.
- R8: Outputs follow the inputs by exactly one clock. A slot has no effect on the lanes of the slot after it: an empty slot that follows a full one yields all lanes invalid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | N | Per-input cell valid flags |
| in_dat | input | N*W | Input payloads, input i at bits i*W +: W |
| out_vld | output | L | Registered lane valid flags, lane 1 at bit 0 |
| out_dat | output | L*W | Registered lane payloads, lane j+1 at bits j*W +: W |
| drop_cnt | output | $clog2(N+1) | Registered count of cells discarded in the previous slot |

## Verification
The main function is driven with single valid inputs at every index, which shows whether a lone cell can lose a match at any tree position. It is also driven with sparse and clustered masks of two to four cells, which show whether losers are really passed down the divisions to fill lanes in order. Masks of five to eight cells, including a full load repeated many times, separate correct truncation and drop counting from duplication or loss of cells. A contested pair after reset shows the toggle order. Back-to-back slots, one full and one empty, show whether state leaks from one slot into the next.

// File: rtl/knockout_pkg.sv
package knockout_pkg;

  localparam int unsigned KO_MAX_PORTS = 64;

  typedef logic [KO_MAX_PORTS-1:0] ko_mask_t;

  // number of set flags in a valid mask
  function automatic int unsigned ko_count(input ko_mask_t m);
    int unsigned c;
    c = 0;
    for (int i = 0; i < KO_MAX_PORTS; i++) c += int'(m[i]);
    return c;
  endfunction

  // cells that cannot be placed on a lane
  function automatic int unsigned ko_excess(input int unsigned k, input int unsigned lanes);
    return (k > lanes) ? (k - lanes) : 0;
  endfunction

  // cells that reach a lane
  function automatic int unsigned ko_forwarded(input int unsigned k, input int unsigned lanes);
    return (k > lanes) ? lanes : k;
  endfunction

endpackage

// File: rtl/ko_element.sv
module ko_element #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         a_vld,
  input  logic [W-1:0] a_dat,
  input  logic         b_vld,
  input  logic [W-1:0] b_dat,
  output logic         win_vld,
  output logic [W-1:0] win_dat,
  output logic         lose_vld,
  output logic [W-1:0] lose_dat
);

  logic favor_b_q;
  logic contested;
  logic take_b;

  assign contested = a_vld & b_vld;
  assign take_b    = b_vld & (~a_vld | favor_b_q);

  always_comb begin
    win_vld  = a_vld | b_vld;
    win_dat  = take_b ? b_dat : a_dat;
    lose_vld = contested;
    lose_dat = '0;
    if (contested) lose_dat = take_b ? a_dat : b_dat;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         favor_b_q <= 1'b0;
    else if (contested) favor_b_q <= ~favor_b_q;
  end

  assert_loser_needs_winner_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lose_vld |-> win_vld);

  assert_cells_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({win_vld, lose_vld}) == $countones({a_vld, b_vld}));

  assert_pair_split_R5: assert property (@(posedge clk) disable iff (!rst_n)
    contested |-> ((win_dat == a_dat && lose_dat == b_dat) ||
                   (win_dat == b_dat && lose_dat == a_dat)));

  assert_toggle_flips_R7: assert property (@(posedge clk) disable iff (!rst_n)
    contested |=> (favor_b_q != $past(favor_b_q)));

endmodule

// File: rtl/ko_division.sv
module ko_division #(
  parameter int unsigned N = 8,
  parameter int unsigned W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   in_vld,
  input  logic [N*W-1:0] in_dat,
  output logic           win_vld,
  output logic [W-1:0]   win_dat,
  output logic [N-1:0]   lose_vld,
  output logic [N*W-1:0] lose_dat
);

  localparam int unsigned NODES = 2 * N;

  // heap numbering: node 1 is the champion, leaves are N..2N-1
  logic [NODES-1:0]        node_vld;
  logic [NODES-1:0][W-1:0] node_dat;

  assign node_vld[0] = 1'b0;
  assign node_dat[0] = '0;

  for (genvar j = 0; j < N; j++) begin : g_leaf
    assign node_vld[N+j] = in_vld[j];
    assign node_dat[N+j] = in_dat[j*W +: W];
  end

  for (genvar e = 1; e < N; e++) begin : g_match
    ko_element #(.W(W)) u_el (
      .clk      (clk),
      .rst_n    (rst_n),
      .a_vld    (node_vld[2*e]),
      .a_dat    (node_dat[2*e]),
      .b_vld    (node_vld[2*e+1]),
      .b_dat    (node_dat[2*e+1]),
      .win_vld  (node_vld[e]),
      .win_dat  (node_dat[e]),
      .lose_vld (lose_vld[e-1]),
      .lose_dat (lose_dat[(e-1)*W +: W])
    );
  end

  // the last loser slot is never fed: N-1 matches yield N-1 losers
  assign lose_vld[N-1]         = 1'b0;
  assign lose_dat[(N-1)*W +: W] = '0;

  assign win_vld = node_vld[1];
  assign win_dat = node_dat[1];

  assert_champion_exists_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|in_vld) == win_vld);

  assert_division_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(lose_vld) + int'(win_vld)) == $countones(in_vld));

endmodule

// File: rtl/knockout_concentrator.sv
module knockout_concentrator
  import knockout_pkg::*;
#(
  parameter  int unsigned N  = 8,
  parameter  int unsigned L  = 4,
  parameter  int unsigned W  = 16,
  localparam int unsigned DW = $clog2(N + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   in_vld,
  input  logic [N*W-1:0] in_dat,
  output logic [L-1:0]   out_vld,
  output logic [L*W-1:0] out_dat,
  output logic [DW-1:0]  drop_cnt
);

  // stage k feeds division k; stage L holds the cells that lost everywhere
  logic [L:0][N-1:0]   stage_vld;
  logic [L:0][N*W-1:0] stage_dat;
  logic [L-1:0]        lane_vld;
  logic [L-1:0][W-1:0] lane_dat;
  logic [DW-1:0]       drop_now;

  assign stage_vld[0] = in_vld;
  assign stage_dat[0] = in_dat;

  for (genvar k = 0; k < L; k++) begin : g_div
    ko_division #(.N(N), .W(W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_vld   (stage_vld[k]),
      .in_dat   (stage_dat[k]),
      .win_vld  (lane_vld[k]),
      .win_dat  (lane_dat[k]),
      .lose_vld (stage_vld[k+1]),
      .lose_dat (stage_dat[k+1])
    );
  end

  assign drop_now = DW'(ko_count(ko_mask_t'(stage_vld[L])));

  logic primed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld  <= '0;
      out_dat  <= '0;
      drop_cnt <= '0;
      primed_q <= 1'b0;
    end else begin
      primed_q <= 1'b1;
      out_vld  <= lane_vld;
      drop_cnt <= drop_now;
      for (int j = 0; j < L; j++)
        out_dat[j*W +: W] <= lane_vld[j] ? lane_dat[j] : '0;
    end
  end

  assert_lanes_packed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld & (out_vld + 1'b1)) == '0);

  assert_drop_means_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_cnt != '0) |-> (&out_vld));

  assert_slot_balance_R5: assert property (@(posedge clk) disable iff (!rst_n)
    primed_q |-> (($countones(out_vld) + int'(drop_cnt)) == $past($countones(in_vld))));

  assert_idle_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld == '0) |=> (out_vld == '0 && drop_cnt == '0));

endmodule

// File: tb/knockout_concentrator_test.sv
module knockout_concentrator_test;

  localparam int N  = 8;
  localparam int L  = 4;
  localparam int W  = 16;
  localparam int DW = $clog2(N + 1);
  localparam int CLK_PERIOD = 10;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [N-1:0]   in_vld;
  logic [N*W-1:0] in_dat;
  logic [L-1:0]   out_vld;
  logic [L*W-1:0] out_dat;
  logic [DW-1:0]  drop_cnt;

  int checks = 0;
  int errors = 0;
  logic [7:0] seq = 8'd0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  knockout_concentrator #(.N(N), .L(L), .W(W)) uut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_dat(in_dat),
    .out_vld(out_vld), .out_dat(out_dat), .drop_cnt(drop_cnt)
  );

  task automatic expect_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int ones(input logic [N-1:0] m);
    int c = 0;
    for (int i = 0; i < N; i++) if (m[i]) c++;
    return c;
  endfunction

  task automatic load(input logic [N-1:0] mask);
    seq++;
    in_vld = mask;
    for (int i = 0; i < N; i++) in_dat[i*W +: W] = {seq, 8'(i)};
  endtask

  // outputs now hold the slot that was loaded with this mask and tag
  task automatic judge(input logic [N-1:0] mask, input logic [7:0] tag, input string req);
    int k, fwd, lanes, dup, foreign;
    logic [N-1:0] seen;
    k   = ones(mask);
    fwd = (k > L) ? L : k;
    lanes = 0; dup = 0; foreign = 0; seen = '0;
    for (int j = 0; j < L; j++) begin
      if (out_vld[j]) begin
        logic [W-1:0] p;
        int idx;
        p = out_dat[j*W +: W];
        idx = int'(p[7:0]);
        if (p[15:8] != tag || idx >= N || !mask[idx]) foreign++;
        else if (seen[idx]) dup++;
        else seen[idx] = 1'b1;
      end
    end
    for (int j = 0; j < L; j++) if (out_vld[j]) lanes++;
    expect_eq(req, "R2 lane mask", int'(out_vld), (1 << fwd) - 1);
    expect_eq(req, "R3 forwarded", lanes, fwd);
    expect_eq(req, "R4 drop_cnt", int'(drop_cnt), k - fwd);
    expect_eq(req, "R5 conservation", lanes + int'(drop_cnt), k);
    expect_eq(req, "R5 foreign payloads", foreign, 0);
    expect_eq(req, "R5 duplicates", dup, 0);
    if (k <= L) expect_eq(req, "R2 all cells placed", int'(seen), int'(mask));
  endtask

  task automatic run_slot(input logic [N-1:0] mask, input string req);
    logic [7:0] tag;
    @(negedge clk);
    load(mask);
    tag = seq;
    @(negedge clk);
    in_vld = '0;
    judge(mask, tag, req);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_vld = '0;
    in_dat = '0;
    repeat (3) @(negedge clk);
    expect_eq("R1", "out_vld in reset", int'(out_vld), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_R1();
    do_reset();
    @(negedge clk);
    expect_eq("R1", "out_vld after reset", int'(out_vld), 0);
    expect_eq("R1", "drop_cnt after reset", int'(drop_cnt), 0);
  endtask

  task automatic t_single_R6();
    for (int i = 0; i < N; i++) begin
      run_slot(N'(1) << i, "R6");
      expect_eq("R6", "lone cell on lane 1", int'(out_dat[7:0]), i);
    end
    run_slot('0, "R6");
    expect_eq("R6", "empty slot lanes", int'(out_vld), 0);
  endtask

  task automatic t_partial_R2();
    run_slot(8'h81, "R2");
    run_slot(8'h24, "R2");
    run_slot(8'h0E, "R2");
    run_slot(8'h55, "R2");
    run_slot(8'hC3, "R2");
    run_slot(8'h90, "R2");
  endtask

  task automatic t_overload_R3_R4();
    run_slot(8'h1F, "R3");
    run_slot(8'hF8, "R3");
    run_slot(8'hAB, "R4");
    run_slot(8'h7E, "R4");
    run_slot(8'hEF, "R4");
    for (int r = 0; r < 12; r++) run_slot(8'hFF, "R5");
  endtask

  task automatic t_toggle_R7();
    do_reset();
    run_slot(8'h03, "R7");
    expect_eq("R7", "first contest lane 1", int'(out_dat[7:0]), 0);
    expect_eq("R7", "first contest lane 2", int'(out_dat[W+7 -: 8]), 1);
    run_slot(8'h03, "R7");
    expect_eq("R7", "second contest lane 1", int'(out_dat[7:0]), 1);
    expect_eq("R7", "second contest lane 2", int'(out_dat[W+7 -: 8]), 0);
    run_slot(8'h03, "R7");
    expect_eq("R7", "third contest lane 1", int'(out_dat[7:0]), 0);
  endtask

  task automatic t_latency_R8();
    logic [7:0] tag_a;
    @(negedge clk);
    load(8'hFF);
    tag_a = seq;
    @(negedge clk);
    judge(8'hFF, tag_a, "R8");
    in_vld = '0;
    @(negedge clk);
    expect_eq("R8", "empty after full lanes", int'(out_vld), 0);
    expect_eq("R8", "empty after full drop", int'(drop_cnt), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset_R1();
    t_single_R6();
    t_partial_R2();
    t_overload_R3_R4();
    t_toggle_R7();
    t_latency_R8();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule